// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

A countdown watchdog attached to a simple register bus. Software writes a reload value into the count register, starts a fresh interval by writing a self-clearing trigger bit, and then sets the run bit. The countdown steps once per time unit. The unit is 1 s, 100 ms or 10 ms, derived from the system clock by a prescaler and chosen at build time. Software must keep writing the trigger bit before the count runs out.

If the count runs out while the timer runs, the block records a sticky fired flag, clears the run bit and sends a single-cycle request. The request goes to the system-reset output or the power-off output, as the action bit selects. A hardware strap input can disable the watchdog. In that state the run bit cannot be set and no expiry request is ever issued.

Top module: `mmio_watchdog`

## Requirements
- R1: After reset, the control register (byte address 0x0) and the count register (byte address 0x4) both read 0 when the strap is low, and both expiry outputs are low.
- R2: Control bit 0 (run, 1 = running) and bit 2 (action, 0 = system reset, 1 = power-off) read back what was written. Bit 3 is read-only and mirrors `wdt_dis_i`, where 1 means disabled.
- R3: Writing 1 to control bit 7 loads the countdown from the count register and restarts the unit prescaler. This applies also while running, so the timer then needs a full new interval before it expires. Bit 7 always reads 0.
- R4: Only bits 15:0 of the count register are stored. On read, bits 31:16 are zero.
- R5: With reload value N, expiry takes effect exactly N x CYC_PER_UNIT clock edges after the edge that sets run, where CYC_PER_UNIT = CLK_HZ / {1, 10, 100} for UNIT_SEL = {0, 1, 2}.
- R6: On expiry the fired bit (control bit 1) is set and run is cleared. Exactly one output pulses, for one cycle: `rst_req_o` when action = 0, or `pwr_off_o` when action = 1.
- R7: Clearing run halts the countdown without any expiry or fired flag.
- R8: Writing 1 to the fired bit clears it. Writing 0 to it leaves it unchanged.
- R9: While `wdt_dis_i` is 1, writes to the run bit have no effect and neither expiry output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdt_dis_i | input | 1 | Hardware strap, 1 disables the watchdog |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| rst_req_o | output | 1 | One-cycle system-reset request |
| pwr_off_o | output | 1 | One-cycle power-off request |

## Verification
The countdown is driven to expiry once with each action setting. This tells apart the routing of the pulse to the two outputs, and shows that both the fired flag and the run clear occur. Each expiry is probed one cycle before and exactly at the predicted edge, which exposes off-by-one errors in the prescaler or the countdown. A re-trigger in mid-interval checks that a full new interval is needed from the trigger edge rather than from the original start. A stop in mid-count and a run attempt under the disable strap must both leave the outputs silent.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_CTRL = 'h0;
  localparam int REG_CNT  = 'h4;

  localparam int B_RUN  = 0;
  localparam int B_FIRE = 1;
  localparam int B_ACT  = 2;
  localparam int B_DIS  = 3;
  localparam int B_TRIG = 7;

  typedef enum logic {ACT_RESET = 1'b0, ACT_PWROFF = 1'b1} act_e;

  function automatic int unit_div(input int sel);
    case (sel)
      1:       return 10;
      2:       return 100;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  generate
    if (CYC <= 1) begin : g_direct
      wire unused_ok = &{1'b0, clk_i, rst_ni};
      assign tick_o = run_i && !restart_i;
    end else begin : g_count
      localparam int PW = $clog2(CYC);
      logic [PW-1:0] pre_q;
      assign tick_o = run_i && !restart_i && (pre_q == PW'(CYC - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  pre_q <= '0;
        else if (!run_i || restart_i) pre_q <= '0;
        else if (tick_o)              pre_q <= '0;
        else                          pre_q <= pre_q + PW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;

  // reaching zero on this tick, or already at zero
  assign expire_o = tick_i && (cur_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_q <= '0;
    else if (load_i)   cur_q <= load_val_i;
    else if (expire_o) cur_q <= '0;
    else if (tick_i)   cur_q <= cur_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              dis_i,
  input  logic              expire_i,
  output logic [31:0]       rdata_o,
  output logic              run_o,
  output logic              fired_o,
  output act_e              act_o,
  output logic              trig_o,
  output logic [CNT_W-1:0]  load_val_o
);
  logic sel_ctrl, sel_cnt, ctrl_we, cnt_we;

  assign sel_ctrl = (addr_i == ADDR_W'(REG_CTRL));
  assign sel_cnt  = (addr_i == ADDR_W'(REG_CNT));
  assign ctrl_we  = we_i && sel_ctrl;
  assign cnt_we   = we_i && sel_cnt;
  assign trig_o   = ctrl_we && wdata_i[B_TRIG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o      <= 1'b0;
      fired_o    <= 1'b0;
      act_o      <= ACT_RESET;
      load_val_o <= '0;
    end else begin
      if (expire_i)                run_o <= 1'b0;
      else if (ctrl_we && !dis_i)  run_o <= wdata_i[B_RUN];

      if (expire_i)                         fired_o <= 1'b1;
      else if (ctrl_we && wdata_i[B_FIRE])  fired_o <= 1'b0;

      if (ctrl_we) act_o <= act_e'(wdata_i[B_ACT]);
      if (cnt_we)  load_val_o <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[B_RUN]  = run_o;
      rdata_o[B_FIRE] = fired_o;
      rdata_o[B_ACT]  = act_o;
      rdata_o[B_DIS]  = dis_i;
    end else if (sel_cnt) begin
      rdata_o[CNT_W-1:0] = load_val_o;
    end
  end
endmodule

// File: rtl/mmio_watchdog.sv
module mmio_watchdog
  import wdt_pkg::*;
#(
  parameter int CLK_HZ   = 250_000_000,
  parameter int UNIT_SEL = 1,
  parameter int ADDR_W   = 4,
  parameter int CNT_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdt_dis_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rst_req_o,
  output logic              pwr_off_o
);
  localparam int CYC_PER_UNIT = CLK_HZ / unit_div(UNIT_SEL);

  logic             run_w, fired_w, trig_w, tick_w, expire_w, run_eff;
  act_e             act_w;
  logic [CNT_W-1:0] load_val_w;

  assign run_eff = run_w && !wdt_dis_i;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .dis_i(wdt_dis_i), .expire_i(expire_w), .rdata_o,
    .run_o(run_w), .fired_o(fired_w), .act_o(act_w),
    .trig_o(trig_w), .load_val_o(load_val_w)
  );

  wdt_prescaler #(.CYC(CYC_PER_UNIT)) u_pre (
    .clk_i, .rst_ni, .run_i(run_eff), .restart_i(trig_w), .tick_o(tick_w)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(trig_w), .load_val_i(load_val_w),
    .tick_i(tick_w), .expire_o(expire_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      pwr_off_o <= 1'b0;
    end else begin
      rst_req_o <= expire_w && (act_w == ACT_RESET);
      pwr_off_o <= expire_w && (act_w == ACT_PWROFF);
    end
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wdt_dis_i,
  input logic run_i,
  input logic fired_i,
  input logic rst_req_o,
  input logic pwr_off_o
);
  // R6
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && pwr_off_o));
  // R6
  rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R6
  pwr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o |=> !pwr_off_o);
  // R6
  fire_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || pwr_off_o) |-> (fired_i && !run_i));
  // R7
  stopped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !(rst_req_o || pwr_off_o));
  // R9
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_dis_i |=> !(rst_req_o || pwr_off_o));
endmodule

bind mmio_watchdog wdt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wdt_dis_i(wdt_dis_i),
  .run_i(run_w), .fired_i(fired_w),
  .rst_req_o(rst_req_o), .pwr_off_o(pwr_off_o)
);

// File: tb/mmio_watchdog_bench.sv
module mmio_watchdog_bench;
  localparam int CYC = 10;  // CLK_HZ 1000, UNIT_SEL 2

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dis = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, pwr_off;

  int n_chk = 0, n_fail = 0, n_rst = 0, n_pwr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mmio_watchdog #(.CLK_HZ(1000), .UNIT_SEL(2), .ADDR_W(4), .CNT_W(16)) u_mmio_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .wdt_dis_i(dis), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req), .pwr_off_o(pwr_off)
  );

  always @(negedge clk) begin
    if (rst_req) n_rst++;
    if (pwr_off) n_pwr++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at the negedge after the edge that sets run
  task automatic arm(input int n, input bit act);
    wr(4'h0, {29'd0, act, 2'b00});
    wr(4'h4, n);
    wr(4'h0, {24'd0, 1'b1, 4'd0, act, 2'b00});
    wr(4'h0, {29'd0, act, 2'b01});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 count", d, 0);
    chk("R1 outputs", {rst_req, pwr_off}, 0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(4'h0, 32'h5);
    rd(4'h0, d); chk("R2 run+action", d, 32'h5);
    wr(4'h0, 32'h4);
    rd(4'h0, d); chk("R2 action only", d, 32'h4);
    dis = 1'b1; #1;
    rd(4'h0, d); chk("R2 strap bit3", d, 32'hC);
    dis = 1'b0;
    wr(4'h0, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(4'h4, 32'hABCD_1234);
    rd(4'h4, d); chk("R4 count low half", d, 32'h0000_1234);
  endtask

  task automatic t_trig_read;
    logic [31:0] d;
    wr(4'h0, 32'h80);
    rd(4'h0, d); chk("R3 trigger reads 0", d, 0);
  endtask

  task automatic t_expire(input int n, input bit act);
    logic [31:0] d;
    int r0, p0;
    r0 = n_rst; p0 = n_pwr;
    arm(n, act);
    idle(n * CYC - 1);
    chk("R5 no pulse before", {rst_req, pwr_off}, 0);
    rd(4'h0, d); chk("R5 not fired before", d[1], 0);
    idle(1);
    chk("R6 pulse routing", {rst_req, pwr_off}, act ? 2'b01 : 2'b10);
    rd(4'h0, d); chk("R6 fired set, run cleared", d[2:0], {act, 2'b10});
    idle(1);
    chk("R6 one-cycle pulse", {rst_req, pwr_off}, 0);
    idle(3 * CYC);
    chk("R6 single reset pulse", n_rst - r0, act ? 0 : 1);
    chk("R6 single poweroff pulse", n_pwr - p0, act ? 1 : 0);
  endtask

  task automatic t_fired_clear;
    logic [31:0] d;
    wr(4'h0, 32'h0);
    rd(4'h0, d); chk("R8 write 0 keeps fired", d[1], 1);
    wr(4'h0, 32'h2);
    rd(4'h0, d); chk("R8 write 1 clears fired", d[1], 0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    int r0;
    r0 = n_rst;
    arm(5, 0);
    idle(20);
    wr(4'h0, 32'h0);
    idle(100);
    chk("R7 no pulse after stop", n_rst - r0, 0);
    rd(4'h0, d); chk("R7 no fired after stop", d, 0);
  endtask

  task automatic t_retrig;
    logic [31:0] d;
    arm(5, 0);
    idle(29);
    wr(4'h0, 32'h81);
    idle(5 * CYC - 1);
    chk("R3 retrigger postpones expiry", {rst_req, pwr_off}, 0);
    idle(1);
    chk("R3 expiry one interval after retrigger", {rst_req, pwr_off}, 2'b10);
    wr(4'h0, 32'h2);
    rd(4'h0, d); chk("R3 cleanup", d, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    int r0, p0;
    r0 = n_rst; p0 = n_pwr;
    dis = 1'b1;
    arm(2, 0);
    rd(4'h0, d); chk("R9 run write ignored", d, 32'h8);
    idle(100);
    chk("R9 no output while disabled", (n_rst - r0) + (n_pwr - p0), 0);
    dis = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_count();
    t_trig_read();
    t_expire(5, 0);
    t_fired_clear();
    t_expire(3, 1);
    wr(4'h0, 32'h2);
    t_stop();
    t_retrig();
    t_disabled();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act timeout exp finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule